// File: doc/BRIEF.md
# Paged effective address generator

This block computes the effective address of a two-byte memory-reference instruction. The address space is 16 bits wide and split into sixteen 4 KB pages. The first instruction byte picks a base register (the program counter or one of three pointers) and an addressing mode. The second byte is a signed displacement. Every addition is confined to the 12-bit page offset, so the page number of the result is always the page number of the base.

In auto-indexed mode the block also produces the new pointer value, with a write strobe for the register file. A negative displacement is a pre-decrement: the pointer is written in the same cycle the address is issued, and the stepped value is the address. A zero or positive displacement is a post-increment: the old pointer is the address, and the block holds the stepped value in a pending slot. It writes that value the first time the sequencer reports that the access has completed.

The sequencer may issue a new instruction in the same cycle as that completion. When this happens, the block shares its single write port between the two updates. It also forwards the pending value if the new instruction uses the same pointer.

Top module: `paged_ea_gen`

## Requirements
- R1: The base register is chosen by opcode bits 1:0: 0 selects the program counter (baseRegs entry 0), 1, 2 and 3 select pointers 1 to 3. Opcode bit 2 is the mode bit, where 0 means relative/indexed and 1 means auto-indexed. Opcode bits 7:3 have no effect.
- R2: In relative/indexed mode, effAddr is {base[15:12], (base[11:0] + sign-extended disp) mod 4096}, for example 1FB4 + 4D gives 1001, and 3005 + F0 gives 3FF5.
- R3: In auto-indexed mode with disp bit 7 set, effAddr is the wrapped sum. In that same issue cycle ptrWrEn is 1, ptrWrSel equals the selected pointer and ptrWrData equals effAddr.
- R4: In auto-indexed mode with disp bit 7 clear, effAddr is the unmodified base and there is no write in the issue cycle. The wrapped sum is written to that pointer in the first later cycle with accessDone high, exactly once.
- R5: The mode bit with selection 0 behaves as relative addressing: no write is ever made for it, and ptrWrSel is never 0 while ptrWrEn is 1.
- R6: Relative/indexed mode makes no pointer write of its own.
- R7: If an instruction issues together with accessDone while a post-increment to the same pointer is pending, the pending value replaces the register as the base. If that instruction is a pre-decrement, its write is the only one, and the pending update is dropped.
- R8: If a pre-decrement issues together with accessDone while a post-increment to another pointer is pending, the pre-decrement is written in the issue cycle and the pending update in the next cycle. No instruction may issue in that next cycle.
- R9: After reset no write is pending and ptrWrEn is 0. An accessDone with nothing pending causes no write.
- R10: A post-increment issued together with the completion of an earlier one writes the earlier value in that cycle and becomes the new pending update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction presented this cycle |
| opcode | input | 8 | First instruction byte |
| disp | input | 8 | Signed displacement byte |
| baseRegs | input | 4x16 | Entry 0 program counter, entries 1-3 pointers |
| accessDone | input | 1 | Memory access of the last issued instruction finished |
| effAddr | output | 16 | Effective address |
| ptrWrEn | output | 1 | Pointer write strobe |
| ptrWrSel | output | 2 | Pointer being written |
| ptrWrData | output | 16 | Value written to the pointer |

## Verification
Two functions can fall in the same cycle: a new issue and the completion of a pending post-increment. The bench arranges this by raising accessDone in the cycle that presents the next instruction. It covers a following post-increment, a pre-decrement on the same pointer, a pre-decrement on a different pointer, and plain indexing through the pending pointer. A behavioural model kept in integers predicts the write port and the address on every clock. It also confirms that the deferred or dropped update shows up, or fails to show up, on the cycles that follow.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef struct packed {
    logic eaFromBase;  // post-increment: address is the unmodified base
    logic fwdBase;     // pending value replaces the register as base
    logic loadPend;    // capture the stepped value into the pending slot
    logic wrFromPend;  // write port sources the pending slot
    logic wrEn;        // write port active
  } eagStrobes_t;
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl #(
  parameter int SEL_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    issue,
  input  logic                    autoMode,
  input  logic [SEL_W-1:0]        sel,
  input  logic                    dispNeg,
  input  logic                    accessDone,
  output eag_pkg::eagStrobes_t    strobes,
  output logic [SEL_W-1:0]        wrSel
);
  logic             pendValid;
  logic             deferValid;
  logic [SEL_W-1:0] pendSel;
  logic             selIsPc;
  logic             autoIdx;
  logic             preDec;
  logic             postInc;
  logic             postDone;
  logic             sameSel;

  assign selIsPc  = (sel == '0);
  assign autoIdx  = issue && autoMode && !selIsPc;
  assign preDec   = autoIdx && dispNeg;
  assign postInc  = autoIdx && !dispNeg;
  assign postDone = pendValid && !deferValid && accessDone;
  assign sameSel  = (pendSel == sel);

  always_comb begin
    strobes            = '0;
    strobes.eaFromBase = postInc;
    strobes.fwdBase    = issue && postDone && sameSel && !selIsPc;
    strobes.loadPend   = postInc;
    wrSel              = pendSel;
    if (preDec) begin
      strobes.wrEn = 1'b1;
      wrSel        = sel;
    end else if (deferValid || postDone) begin
      strobes.wrEn       = 1'b1;
      strobes.wrFromPend = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid  <= 1'b0;
      deferValid <= 1'b0;
      pendSel    <= '0;
    end else if (deferValid) begin
      deferValid <= 1'b0;
      pendValid  <= 1'b0;
    end else if (preDec && postDone) begin
      if (sameSel) pendValid  <= 1'b0;
      else         deferValid <= 1'b1;
    end else begin
      if (postDone) pendValid <= 1'b0;
      if (postInc) begin
        pendValid <= 1'b1;
        pendSel   <= sel;
      end
    end
  end

  AST_PEND_NOT_PC: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> (pendSel != '0)); // R5
  AST_DEFER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    deferValid |=> !deferValid); // R8
  AST_NO_ISSUE_ON_DEFER: assert property (@(posedge clk) disable iff (!rstN)
    deferValid |-> !issue); // R8
  AST_DEFER_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    deferValid |=> !pendValid); // R4
endmodule

// File: rtl/eag_dp.sv
module eag_dp #(
  parameter int ADDR_W  = 16,
  parameter int PAGE_W  = 4,
  parameter int DISP_W  = 8,
  parameter int SEL_W   = 2,
  localparam int NUM_REG = 2**SEL_W,
  localparam int OFF_W   = ADDR_W - PAGE_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_REG-1:0][ADDR_W-1:0]   baseRegs,
  input  logic [SEL_W-1:0]                 sel,
  input  logic [DISP_W-1:0]                disp,
  input  eag_pkg::eagStrobes_t             strobes,
  output logic [ADDR_W-1:0]                effAddr,
  output logic [ADDR_W-1:0]                wrData
);
  logic [ADDR_W-1:0] pendVal;
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  dispExt;
  logic [OFF_W-1:0]  offSum;
  logic [ADDR_W-1:0] stepped;

  assign base    = strobes.fwdBase ? pendVal : baseRegs[sel];
  assign dispExt = {{(OFF_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign offSum  = base[OFF_W-1:0] + dispExt;
  assign stepped = {base[ADDR_W-1:OFF_W], offSum};
  assign effAddr = strobes.eaFromBase ? base : stepped;
  assign wrData  = strobes.wrFromPend ? pendVal : stepped;

  always_ff @(posedge clk) begin
    if (!rstN)                 pendVal <= '0;
    else if (strobes.loadPend) pendVal <= stepped;
  end

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.fwdBase |-> (effAddr[ADDR_W-1:OFF_W] == baseRegs[sel][ADDR_W-1:OFF_W])); // R2
  AST_PRE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEn && !strobes.wrFromPend) |-> (wrData == effAddr)); // R3
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen #(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 4,
  parameter int DISP_W   = 8,
  parameter int SEL_W    = 2,
  parameter int OPC_W    = 8,
  parameter int MODE_BIT = 2,
  localparam int NUM_REG = 2**SEL_W
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           issue,
  input  logic [OPC_W-1:0]               opcode,
  input  logic [DISP_W-1:0]              disp,
  input  logic [NUM_REG-1:0][ADDR_W-1:0] baseRegs,
  input  logic                           accessDone,
  output logic [ADDR_W-1:0]              effAddr,
  output logic                           ptrWrEn,
  output logic [SEL_W-1:0]               ptrWrSel,
  output logic [ADDR_W-1:0]              ptrWrData
);
  eag_pkg::eagStrobes_t strobes;
  logic [SEL_W-1:0]     sel;

  assign sel = opcode[SEL_W-1:0];

  eag_ctrl #(.SEL_W(SEL_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issue      (issue),
    .autoMode   (opcode[MODE_BIT]),
    .sel        (sel),
    .dispNeg    (disp[DISP_W-1]),
    .accessDone (accessDone),
    .strobes    (strobes),
    .wrSel      (ptrWrSel)
  );

  eag_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DISP_W(DISP_W), .SEL_W(SEL_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .baseRegs (baseRegs),
    .sel      (sel),
    .disp     (disp),
    .strobes  (strobes),
    .effAddr  (effAddr),
    .wrData   (ptrWrData)
  );

  assign ptrWrEn = strobes.wrEn;

  AST_WR_NOT_PC: assert property (@(posedge clk) disable iff (!rstN)
    ptrWrEn |-> (ptrWrSel != '0)); // R5
  AST_PLAIN_ALONE_NO_WR: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !opcode[MODE_BIT] && !accessDone && !$past(issue && accessDone)
     && !$past(ptrWrEn && issue)) |-> !ptrWrEn); // R6
endmodule

// File: tb/test_paged_ea_gen.sv
module test_paged_ea_gen;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             issue = 1'b0;
  logic [7:0]       opcode = '0;
  logic [7:0]       disp = '0;
  logic [3:0][15:0] baseRegs;
  logic             accessDone = 1'b0;
  logic [15:0]      effAddr;
  logic             ptrWrEn;
  logic [1:0]       ptrWrSel;
  logic [15:0]      ptrWrData;

  int checks = 0;
  int failures = 0;

  // behavioural model state
  bit mPend = 0;
  bit mDefer = 0;
  int mSel = 0;
  int mVal = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_ea_gen i_paged_ea_gen (
    .clk(clk), .rstN(rstN), .issue(issue), .opcode(opcode), .disp(disp),
    .baseRegs(baseRegs), .accessDone(accessDone), .effAddr(effAddr),
    .ptrWrEn(ptrWrEn), .ptrWrSel(ptrWrSel), .ptrWrData(ptrWrData)
  );

  function automatic int pageAdd(int b, int d);
    int sd;
    sd = (d >= 128) ? d - 256 : d;
    return (b & 'hF000) | ((b + sd) & 'hFFF);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive, compare against model, advance model
  task automatic cyc(string tag, bit iss, int op, int d, bit done);
    int sel, base, sum, expEa, expWrSel, expWrData;
    bit autoI, neg, postDone, fwd, expWr, pre, post;
    @(negedge clk);
    issue = iss; opcode = op[7:0]; disp = d[7:0]; accessDone = done;
    #1;
    sel      = op & 3;
    autoI    = iss && ((op >> 2) & 1) && sel != 0;
    neg      = d >= 128;
    pre      = autoI && neg;
    post     = autoI && !neg;
    postDone = mPend && !mDefer && done;
    fwd      = iss && postDone && mSel == sel && sel != 0;
    base     = fwd ? mVal : int'(baseRegs[sel]);
    sum      = pageAdd(base, d);
    expEa    = post ? base : sum;
    expWr = 0; expWrSel = 0; expWrData = 0;
    if (pre) begin
      expWr = 1; expWrSel = sel; expWrData = sum;
    end else if (mDefer || postDone) begin
      expWr = 1; expWrSel = mSel; expWrData = mVal;
    end
    check(tag, "ptrWrEn", int'(ptrWrEn), int'(expWr));
    if (expWr) begin
      check(tag, "ptrWrSel", int'(ptrWrSel), expWrSel);
      check(tag, "ptrWrData", int'(ptrWrData), expWrData);
    end
    if (iss) check(tag, "effAddr", int'(effAddr), expEa);
    // state advance, mirrors the requirements
    if (mDefer) begin
      mDefer = 0; mPend = 0;
    end else if (pre && postDone) begin
      if (mSel == sel) mPend = 0;
      else mDefer = 1;
    end else begin
      if (postDone) mPend = 0;
      if (post) begin
        mPend = 1; mSel = sel; mVal = sum;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    baseRegs[0] = 16'h1FB4;
    baseRegs[1] = 16'h3005;
    baseRegs[2] = 16'h0FFE;
    baseRegs[3] = 16'h8010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R9", "ptrWrEn after reset", int'(ptrWrEn), 0);
    cyc("R9", 0, 'h00, 'h00, 1);            // stray completion: no write
    // R2 relative, R1 field decode
    cyc("R2", 1, 'h00, 'h4D, 0);            // 1FB4+4D -> 1001
    check("R2", "page wrap example", int'(effAddr), 'h1001);
    cyc("R2", 1, 'h01, 'hF0, 0);            // 3005-16 -> 3FF5
    check("R2", "negative wrap", int'(effAddr), 'h3FF5);
    cyc("R1", 1, 'hF9, 'h4D, 0);            // high opcode bits ignored
    check("R1", "upper opcode bits", int'(effAddr), 'h3052);
    cyc("R6", 1, 'h02, 'h05, 0);            // 0FFE+5 -> 0003, no write
    check("R6", "plain no write", int'(ptrWrEn), 0);
    // R5 auto through PC
    cyc("R5", 1, 'h04, 'h80, 0);
    check("R5", "pc auto ea", int'(effAddr), 'h1F34);
    cyc("R5", 0, 'h00, 'h00, 1);            // nothing pending from it
    // R3 pre-decrement
    cyc("R3", 1, 'h06, 'hFE, 0);
    check("R3", "predec data", int'(ptrWrData), 'h0FFC);
    cyc("R3", 1, 'h07, 'h80, 0);            // 8010-128 wraps to 8F90
    check("R3", "predec wrap", int'(ptrWrData), 'h8F90);
    // R4 post-increment
    cyc("R4", 1, 'h05, 'h10, 0);
    check("R4", "postinc ea is base", int'(effAddr), 'h3005);
    cyc("R4", 0, 'h00, 'h00, 0);
    cyc("R4", 0, 'h00, 'h00, 1);
    check("R4", "postinc data", int'(ptrWrData), 'h3015);
    cyc("R4", 0, 'h00, 'h00, 1);            // only once
    cyc("R4", 1, 'h06, 'h00, 0);
    cyc("R4", 0, 'h00, 'h00, 1);
    // R10 back-to-back post-increments
    cyc("R10", 1, 'h07, 'h7F, 0);
    cyc("R10", 1, 'h05, 'h02, 1);
    check("R10", "old written", int'(ptrWrSel), 3);
    cyc("R10", 0, 'h00, 'h00, 1);
    check("R10", "new written", int'(ptrWrData), 'h3007);
    // R7 same pointer collision, pre-decrement
    cyc("R7", 1, 'h05, 'h20, 0);
    cyc("R7", 1, 'h05, 'hFC, 1);
    check("R7", "forwarded predec", int'(effAddr), 'h3021);
    cyc("R7", 0, 'h00, 'h00, 1);
    check("R7", "pending dropped", int'(ptrWrEn), 0);
    // R7 plain access through the pending pointer
    cyc("R7", 1, 'h05, 'h20, 0);
    cyc("R7", 1, 'h01, 'h01, 1);
    check("R7", "forwarded plain", int'(effAddr), 'h3026);
    // R8 different pointer collision
    cyc("R8", 1, 'h06, 'h03, 0);
    cyc("R8", 1, 'h07, 'hF8, 1);
    check("R8", "predec first", int'(ptrWrData), 'h8008);
    cyc("R8", 0, 'h00, 'h00, 0);
    check("R8", "deferred write", int'(ptrWrData), 'h0001);
    cyc("R8", 0, 'h00, 'h00, 1);
    check("R8", "no repeat", int'(ptrWrEn), 0);
    // R9 reset in the middle of a pending update
    cyc("R9", 1, 'h05, 'h10, 0);
    @(negedge clk);
    issue = 0; accessDone = 0; rstN = 0;
    mPend = 0; mDefer = 0;
    @(negedge clk);
    rstN = 1;
    cyc("R9", 0, 'h00, 'h00, 1);
    check("R9", "pending cleared", int'(ptrWrEn), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule